// File: doc/BRIEF.md
# Backplane Link Bring-Up Sequencer

This block is the top-level state controller that brings a backplane serial link up. After a hardware reset or a sequencer restart it first asks the PCS for a reconfiguration. It then starts auto-negotiation if negotiation is active, and link training if training is active. Finally it settles in data mode with link ready asserted. The negotiation and training engines are separate blocks. This controller only strobes them to start and watches their done, fail and timeout indications.

Failures have fixed routes. A negotiation failure or timeout retries negotiation. A training failure follows a selectable response: stay in data mode, go back to negotiation, or retry training. The forced protocol mode and the FEC request are captured only when a sequencer restart is requested, so writing them mid-run has no effect on the running flow. Three internal timers police the states: a negotiation timer, a training timer and a link-fail timer that runs while in data mode. Each timer's expiry is handled as described in the requirements below.

States: RECFG (reconfiguration requested), AN_GO (one-cycle negotiation start), AN_RUN, LT_GO (one-cycle training start), LT_RUN, DATA. Transitions:
- RECFG→AN_GO/LT_GO/DATA happens on `recfg_done`.
- AN_RUN→LT_GO/DATA happens on `an_done`.
- AN_RUN→AN_GO happens on a negotiation failure or timeout.
- LT_RUN→DATA happens on `lt_done`.
- LT_RUN→DATA/AN_GO/LT_GO happens on a training failure, following the selected response.
- DATA→RECFG happens on link-fail timer expiry.
- Any state→RECFG happens on `seq_restart`.

Top module: `link_seq_ctrl`

## Requirements
- R1: During and after reset the controller is in RECFG: `recfg_req`=1, `link_ready`=0, both timeout flags 0, `fec_req_adv` equals parameter FEC_REQ_RST, and the captured mode is 0.
- R2: The bring-up order is as follows. `recfg_req` stays high until `recfg_done`. Next comes a one-cycle `an_start` if negotiation is active. After `an_done` comes a one-cycle `lt_start` if training is active. After that `link_ready` asserts. Each step's output appears in the cycle after its trigger.
- R3: `seq_restart` wins over every other input in every state. In the next cycle `recfg_req`=1 and `link_ready`=0.
- R4: `force_mode` is captured only on `seq_restart`, with this encoding: 0 means negotiation follows `an_en` and training follows `lt_en`; 1 means negotiation only; 2 means training only; 3 means neither. A change at any other time has no effect.
- R5: With `fail_resp`=1, a training failure moves the controller to DATA.
- R6: With `fail_resp`=0, a training failure issues `an_start` next if negotiation is active, and `lt_start` otherwise.
- R7: `an_fail` during negotiation issues `an_start` again in the next cycle.
- R8: After AN_TMO cycles in AN_RUN with neither done nor fail, `an_timeout` sets and negotiation restarts. The flag stays set until `seq_restart` clears it. With `an_tmr_dis`=1 the timer never expires.
- R9: After LT_TMO cycles in LT_RUN with neither done nor fail, `lt_timeout` sets and the training-failure route of R5/R6 is taken. The flag stays set until `seq_restart` clears it.
- R10: An `lt_done` with `ber_fail_en`=1 and `lt_ber_nz`=1 counts as a training failure. With `ber_fail_en`=0, `lt_ber_nz` is ignored.
- R11: In DATA, `link_fail` held for LF_TMO consecutive cycles restarts bring-up at RECFG, unless `lf_tmr_dis`=1.
- R12: `fec_req_adv` loads `fec_req_in` only on `seq_restart`.
- R13: `link_ready` is high only in DATA. At most one of `link_ready`, `recfg_req`, `an_start` and `lt_start` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_restart | input | 1 | Sequencer restart pulse |
| an_en | input | 1 | Negotiation enable (mode 0) |
| lt_en | input | 1 | Training enable (mode 0) |
| force_mode | input | 2 | Forced protocol code, captured on restart |
| fail_resp | input | 1 | 1: training failure goes to data mode |
| an_tmr_dis | input | 1 | Disable negotiation timer |
| lf_tmr_dis | input | 1 | Disable link-fail timer |
| ber_fail_en | input | 1 | Treat non-zero final error count as failure |
| lt_ber_nz | input | 1 | Final training error count is non-zero |
| fec_req_in | input | 1 | Requested FEC advertisement |
| recfg_done | input | 1 | PCS reconfiguration finished |
| an_done | input | 1 | Negotiation completed |
| an_fail | input | 1 | Negotiation failed |
| lt_done | input | 1 | Training completed |
| lt_fail | input | 1 | Training failed |
| link_fail | input | 1 | Link lost indication |
| link_ready | output | 1 | Link is in data mode |
| recfg_req | output | 1 | PCS reconfiguration request |
| an_start | output | 1 | Negotiation start/restart strobe |
| lt_start | output | 1 | Training start/restart strobe |
| an_timeout | output | 1 | Latched negotiation timeout |
| lt_timeout | output | 1 | Latched training timeout |
| fec_req_adv | output | 1 | FEC request in effect |

## Verification
The flow is driven through several mode patterns, and each pattern separates a different decode or route:
- Both enables set, which exercises the full path.
- Forced mode 3, which skips both engines and separates the captured code from the live enables.
- Forced negotiation-only, with fail and timeout retries, which separates done/fail/timeout priority.
- Training-only with failure response 0, which separates the retry-training route from the renegotiate route.
- Both enabled with failure responses 0 and 1.

Mid-run writes of the mode and FEC request while in data mode show whether capture is tied to restart alone. Link-fail held with the timer disabled and then enabled separates the timer gate from the expiry count.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

    typedef enum logic [2:0] {
        ST_RECFG  = 3'd0,
        ST_AN_GO  = 3'd1,
        ST_AN_RUN = 3'd2,
        ST_LT_GO  = 3'd3,
        ST_LT_RUN = 3'd4,
        ST_DATA   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        FM_FOLLOW  = 2'd0,
        FM_AN_ONLY = 2'd1,
        FM_LT_ONLY = 2'd2,
        FM_NONE    = 2'd3
    } force_mode_e;

    localparam int unsigned TMR_AN  = 0;
    localparam int unsigned TMR_LT  = 1;
    localparam int unsigned TMR_LF  = 2;
    localparam int unsigned TMR_CNT = 3;

endpackage

// File: rtl/link_seq_cfg.sv
module link_seq_cfg
    import link_seq_pkg::*;
#(
    parameter bit FEC_REQ_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_restart,
    input  logic [1:0] force_mode,
    input  logic       an_en,
    input  logic       lt_en,
    input  logic       fec_req_in,
    output logic       an_act,
    output logic       lt_act,
    output logic       fec_adv
);

    force_mode_e mode_q;
    logic        fec_q;

    // Mode and FEC request only move on a sequencer restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= FM_FOLLOW;
            fec_q  <= FEC_REQ_RST;
        end else if (seq_restart) begin
            mode_q <= force_mode_e'(force_mode);
            fec_q  <= fec_req_in;
        end
    end

    always_comb begin
        an_act = 1'b0;
        lt_act = 1'b0;
        unique case (mode_q)
            FM_FOLLOW: begin
                an_act = an_en;
                lt_act = lt_en;
            end
            FM_AN_ONLY: an_act = 1'b1;
            FM_LT_ONLY: lt_act = 1'b1;
            FM_NONE: begin
                an_act = 1'b0;
                lt_act = 1'b0;
            end
            default: begin
                an_act = 1'b0;
                lt_act = 1'b0;
            end
        endcase
    end

    assign fec_adv = fec_q;

endmodule

// File: rtl/link_seq_timer.sv
module link_seq_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    // Counts consecutive cycles with run high; any gap clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/link_seq_fsm.sv
module link_seq_fsm
    import link_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_restart,
    input  logic       an_act,
    input  logic       lt_act,
    input  logic       fail_resp,
    input  logic       ber_fail_en,
    input  logic       lt_ber_nz,
    input  logic       recfg_done,
    input  logic       an_done,
    input  logic       an_fail,
    input  logic       lt_done,
    input  logic       lt_fail,
    input  logic       an_exp,
    input  logic       lt_exp,
    input  logic       lf_exp,
    output seq_state_e state,
    output logic       an_to,
    output logic       lt_to
);

    seq_state_e state_q, state_d;
    logic       an_to_q, lt_to_q;
    logic       ber_bad;
    logic       lt_hard_fail;
    logic       an_tmo_evt, lt_tmo_evt;
    seq_state_e lt_fail_dst;

    assign ber_bad      = lt_done && ber_fail_en && lt_ber_nz;
    assign lt_hard_fail = lt_fail || ber_bad;
    assign an_tmo_evt   = (state_q == ST_AN_RUN) && !an_done && !an_fail && an_exp;
    assign lt_tmo_evt   = (state_q == ST_LT_RUN) && !lt_hard_fail && !lt_done && lt_exp;

    // Destination of any training failure.
    always_comb begin
        if (fail_resp) begin
            lt_fail_dst = ST_DATA;
        end else if (an_act) begin
            lt_fail_dst = ST_AN_GO;
        end else begin
            lt_fail_dst = ST_LT_GO;
        end
    end

    always_comb begin
        state_d = state_q;
        if (seq_restart) begin
            state_d = ST_RECFG;
        end else begin
            unique case (state_q)
                ST_RECFG: begin
                    if (recfg_done) begin
                        if (an_act) begin
                            state_d = ST_AN_GO;
                        end else if (lt_act) begin
                            state_d = ST_LT_GO;
                        end else begin
                            state_d = ST_DATA;
                        end
                    end
                end
                ST_AN_GO:  state_d = ST_AN_RUN;
                ST_AN_RUN: begin
                    if (an_done) begin
                        state_d = lt_act ? ST_LT_GO : ST_DATA;
                    end else if (an_fail || an_exp) begin
                        state_d = ST_AN_GO;
                    end
                end
                ST_LT_GO:  state_d = ST_LT_RUN;
                ST_LT_RUN: begin
                    if (lt_hard_fail) begin
                        state_d = lt_fail_dst;
                    end else if (lt_done) begin
                        state_d = ST_DATA;
                    end else if (lt_exp) begin
                        state_d = lt_fail_dst;
                    end
                end
                ST_DATA: begin
                    if (lf_exp) begin
                        state_d = ST_RECFG;
                    end
                end
                default: state_d = ST_RECFG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECFG;
        end else begin
            state_q <= state_d;
        end
    end

    // Timeout flags: sticky, cleared only by a sequencer restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            an_to_q <= 1'b0;
            lt_to_q <= 1'b0;
        end else if (seq_restart) begin
            an_to_q <= 1'b0;
            lt_to_q <= 1'b0;
        end else begin
            if (an_tmo_evt) begin
                an_to_q <= 1'b1;
            end
            if (lt_tmo_evt) begin
                lt_to_q <= 1'b1;
            end
        end
    end

    assign state = state_q;
    assign an_to = an_to_q;
    assign lt_to = lt_to_q;

endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
    import link_seq_pkg::*;
#(
    parameter int unsigned AN_TMO      = 64,
    parameter int unsigned LT_TMO      = 96,
    parameter int unsigned LF_TMO      = 16,
    parameter bit          FEC_REQ_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_restart,
    input  logic       an_en,
    input  logic       lt_en,
    input  logic [1:0] force_mode,
    input  logic       fail_resp,
    input  logic       an_tmr_dis,
    input  logic       lf_tmr_dis,
    input  logic       ber_fail_en,
    input  logic       lt_ber_nz,
    input  logic       fec_req_in,
    input  logic       recfg_done,
    input  logic       an_done,
    input  logic       an_fail,
    input  logic       lt_done,
    input  logic       lt_fail,
    input  logic       link_fail,
    output logic       link_ready,
    output logic       recfg_req,
    output logic       an_start,
    output logic       lt_start,
    output logic       an_timeout,
    output logic       lt_timeout,
    output logic       fec_req_adv
);

    localparam int unsigned TMO_TAB [TMR_CNT] = '{AN_TMO, LT_TMO, LF_TMO};

    seq_state_e         state;
    logic               an_act, lt_act;
    logic [TMR_CNT-1:0] tmr_run, tmr_exp;

    link_seq_cfg #(
        .FEC_REQ_RST (FEC_REQ_RST)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_restart (seq_restart),
        .force_mode  (force_mode),
        .an_en       (an_en),
        .lt_en       (lt_en),
        .fec_req_in  (fec_req_in),
        .an_act      (an_act),
        .lt_act      (lt_act),
        .fec_adv     (fec_req_adv)
    );

    assign tmr_run[TMR_AN] = (state == ST_AN_RUN) && !an_tmr_dis;
    assign tmr_run[TMR_LT] = (state == ST_LT_RUN);
    assign tmr_run[TMR_LF] = (state == ST_DATA) && link_fail && !lf_tmr_dis;

    for (genvar g = 0; g < TMR_CNT; g++) begin : g_tmr
        link_seq_timer #(
            .LIMIT (TMO_TAB[g])
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (tmr_run[g]),
            .expired (tmr_exp[g])
        );
    end

    link_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_restart (seq_restart),
        .an_act      (an_act),
        .lt_act      (lt_act),
        .fail_resp   (fail_resp),
        .ber_fail_en (ber_fail_en),
        .lt_ber_nz   (lt_ber_nz),
        .recfg_done  (recfg_done),
        .an_done     (an_done),
        .an_fail     (an_fail),
        .lt_done     (lt_done),
        .lt_fail     (lt_fail),
        .an_exp      (tmr_exp[TMR_AN]),
        .lt_exp      (tmr_exp[TMR_LT]),
        .lf_exp      (tmr_exp[TMR_LF]),
        .state       (state),
        .an_to       (an_timeout),
        .lt_to       (lt_timeout)
    );

    // Moore output decode.
    always_comb begin
        link_ready = 1'b0;
        recfg_req  = 1'b0;
        an_start   = 1'b0;
        lt_start   = 1'b0;
        unique case (state)
            ST_RECFG:  recfg_req  = 1'b1;
            ST_AN_GO:  an_start   = 1'b1;
            ST_LT_GO:  lt_start   = 1'b1;
            ST_DATA:   link_ready = 1'b1;
            ST_AN_RUN, ST_LT_RUN: ;
            default:   recfg_req  = 1'b0;
        endcase
    end

endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic seq_restart,
    input logic link_ready,
    input logic recfg_req,
    input logic an_start,
    input logic lt_start,
    input logic an_timeout,
    input logic lt_timeout,
    input logic fec_req_adv
);

    assert_outputs_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_ready, recfg_req, an_start, lt_start}));

    assert_restart_reconfig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart |=> (recfg_req && !link_ready));

    assert_an_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start && !seq_restart) |=> !an_start);

    assert_lt_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_start && !seq_restart) |=> !lt_start);

    assert_an_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (an_timeout && !seq_restart) |=> an_timeout);

    assert_lt_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_timeout && !seq_restart) |=> lt_timeout);

    assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_restart |=> (!an_timeout && !lt_timeout));

    assert_fec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_restart |=> $stable(fec_req_adv));

endmodule

bind link_seq_ctrl link_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_restart (seq_restart),
    .link_ready  (link_ready),
    .recfg_req   (recfg_req),
    .an_start    (an_start),
    .lt_start    (lt_start),
    .an_timeout  (an_timeout),
    .lt_timeout  (lt_timeout),
    .fec_req_adv (fec_req_adv)
);

// File: tb/sim_link_seq_ctrl.sv
module sim_link_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AN_TMO = 20;
    localparam int LT_TMO = 24;
    localparam int LF_TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_restart = 0, an_en = 1, lt_en = 1;
    logic [1:0] force_mode = 2'd0;
    logic fail_resp = 0, an_tmr_dis = 0, lf_tmr_dis = 0, ber_fail_en = 0, lt_ber_nz = 0;
    logic fec_req_in = 0, recfg_done = 0, an_done = 0, an_fail = 0, lt_done = 0, lt_fail = 0;
    logic link_fail = 0;
    logic link_ready, recfg_req, an_start, lt_start, an_timeout, lt_timeout, fec_req_adv;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_seq_ctrl #(
        .AN_TMO (AN_TMO), .LT_TMO (LT_TMO), .LF_TMO (LF_TMO), .FEC_REQ_RST (1'b0)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .seq_restart (seq_restart), .an_en (an_en),
        .lt_en (lt_en), .force_mode (force_mode), .fail_resp (fail_resp),
        .an_tmr_dis (an_tmr_dis), .lf_tmr_dis (lf_tmr_dis), .ber_fail_en (ber_fail_en),
        .lt_ber_nz (lt_ber_nz), .fec_req_in (fec_req_in), .recfg_done (recfg_done),
        .an_done (an_done), .an_fail (an_fail), .lt_done (lt_done), .lt_fail (lt_fail),
        .link_fail (link_fail), .link_ready (link_ready), .recfg_req (recfg_req),
        .an_start (an_start), .lt_start (lt_start), .an_timeout (an_timeout),
        .lt_timeout (lt_timeout), .fec_req_adv (fec_req_adv)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int P_RECFG = 0, P_ANGO = 1, P_ANRUN = 2, P_LTGO = 3, P_LTRUN = 4, P_DATA = 5;
    int m_ph = P_RECFG;
    int m_mode = 0;
    int m_an_n = 0, m_lt_n = 0, m_lf_n = 0;
    bit m_fec = 0, m_an_to = 0, m_lt_to = 0;

    function automatic bit m_an_on();
        return (m_mode == 0) ? an_en : (m_mode == 1);
    endfunction
    function automatic bit m_lt_on();
        return (m_mode == 0) ? lt_en : (m_mode == 2);
    endfunction
    function automatic int m_lt_fail_to();
        if (fail_resp) return P_DATA;
        return m_an_on() ? P_ANGO : P_LTGO;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = P_RECFG; m_mode = 0; m_fec = 0; m_an_to = 0; m_lt_to = 0;
            m_an_n = 0; m_lt_n = 0; m_lf_n = 0;
        end else if (seq_restart) begin
            m_ph = P_RECFG; m_mode = int'(force_mode); m_fec = fec_req_in;
            m_an_to = 0; m_lt_to = 0; m_an_n = 0; m_lt_n = 0; m_lf_n = 0;
        end else begin
            case (m_ph)
                P_RECFG: if (recfg_done)
                    m_ph = m_an_on() ? P_ANGO : (m_lt_on() ? P_LTGO : P_DATA);
                P_ANGO: begin m_ph = P_ANRUN; m_an_n = 0; end
                P_ANRUN: begin
                    if (an_done) m_ph = m_lt_on() ? P_LTGO : P_DATA;
                    else if (an_fail) m_ph = P_ANGO;
                    else if (!an_tmr_dis) begin
                        m_an_n++;
                        if (m_an_n == AN_TMO) begin m_an_to = 1; m_ph = P_ANGO; end
                    end else m_an_n = 0;
                end
                P_LTGO: begin m_ph = P_LTRUN; m_lt_n = 0; end
                P_LTRUN: begin
                    if (lt_fail || (lt_done && ber_fail_en && lt_ber_nz)) m_ph = m_lt_fail_to();
                    else if (lt_done) m_ph = P_DATA;
                    else begin
                        m_lt_n++;
                        if (m_lt_n == LT_TMO) begin m_lt_to = 1; m_ph = m_lt_fail_to(); end
                    end
                end
                P_DATA: begin
                    if (link_fail && !lf_tmr_dis) begin
                        m_lf_n++;
                        if (m_lf_n == LF_TMO) begin m_ph = P_RECFG; m_lf_n = 0; end
                    end else m_lf_n = 0;
                end
                default: m_ph = P_RECFG;
            endcase
            if (m_ph != P_DATA) m_lf_n = 0;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R13 link_ready", int'(link_ready), int'(m_ph == P_DATA));
            check("R2 recfg_req", int'(recfg_req), int'(m_ph == P_RECFG));
            check("R2 an_start", int'(an_start), int'(m_ph == P_ANGO));
            check("R2 lt_start", int'(lt_start), int'(m_ph == P_LTGO));
            check("R8 an_timeout", int'(an_timeout), int'(m_an_to));
            check("R9 lt_timeout", int'(lt_timeout), int'(m_lt_to));
            check("R12 fec_req_adv", int'(fec_req_adv), int'(m_fec));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_restart();
        seq_restart = 1; tick(1); seq_restart = 0;
    endtask
    task automatic do_recfg();
        recfg_done = 1; tick(1); recfg_done = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 recfg_req in reset", int'(recfg_req), 1);
        check("R1 link_ready in reset", int'(link_ready), 0);
        rst_n = 1;
        tick(2);
        check("R1 flags after reset", int'(an_timeout | lt_timeout), 0);
        check("R1 fec default", int'(fec_req_adv), 0);
        check("R2 recfg held", int'(recfg_req), 1);

        // R2 full path
        do_recfg();
        check("R2 an_start after recfg", int'(an_start), 1);
        tick(3);
        an_done = 1; tick(1); an_done = 0;
        check("R2 lt_start after an_done", int'(lt_start), 1);
        tick(2);
        lt_done = 1; tick(1); lt_done = 0;
        check("R2 link_ready after lt_done", int'(link_ready), 1);

        // R4 / R12: writes without restart ignored
        force_mode = 2'd3; fec_req_in = 1; an_en = 0;
        tick(4);
        check("R4 mode write ignored", int'(link_ready), 1);
        check("R12 fec write ignored", int'(fec_req_adv), 0);
        do_restart();
        check("R3 restart reconfig", int'(recfg_req), 1);
        check("R3 ready drops", int'(link_ready), 0);
        check("R12 fec loaded", int'(fec_req_adv), 1);
        do_recfg();
        check("R4 mode 3 skips engines", int'(link_ready), 1);

        // R7 / R8 with negotiation-only mode
        force_mode = 2'd1; an_en = 1;
        do_restart();
        do_recfg();
        check("R4 mode 1 starts negotiation", int'(an_start), 1);
        tick(1);
        an_fail = 1; tick(1); an_fail = 0;
        check("R7 retry after an_fail", int'(an_start), 1);
        tick(1);
        tick(AN_TMO - 1);
        check("R8 no timeout early", int'(an_timeout), 0);
        tick(1);
        check("R8 timeout flag", int'(an_timeout), 1);
        check("R8 timeout restarts negotiation", int'(an_start), 1);
        tick(1);
        an_done = 1; tick(1); an_done = 0;
        check("R4 mode 1 no training", int'(link_ready), 1);
        check("R8 flag sticky", int'(an_timeout), 1);
        do_restart();
        check("R8 flag cleared by restart", int'(an_timeout), 0);
        do_recfg();
        an_tmr_dis = 1;
        tick(AN_TMO * 2);
        check("R8 disabled timer", int'(an_timeout), 0);
        an_done = 1; tick(1); an_done = 0;
        an_tmr_dis = 0;

        // R6 / R9 / R10: training only via enables
        force_mode = 2'd0; an_en = 0; lt_en = 1; fail_resp = 0;
        do_restart();
        do_recfg();
        check("R2 training start", int'(lt_start), 1);
        tick(1);
        lt_fail = 1; tick(1); lt_fail = 0;
        check("R6 retry training", int'(lt_start), 1);
        tick(1);
        tick(LT_TMO);
        check("R9 timeout flag", int'(lt_timeout), 1);
        check("R9 failure route", int'(lt_start), 1);
        tick(1);
        ber_fail_en = 1; lt_ber_nz = 1;
        lt_done = 1; tick(1); lt_done = 0;
        check("R10 nonzero counts as fail", int'(lt_start), 1);
        tick(1);
        ber_fail_en = 0;
        lt_done = 1; tick(1); lt_done = 0;
        check("R10 ignored when option off", int'(link_ready), 1);
        check("R9 flag sticky", int'(lt_timeout), 1);
        lt_ber_nz = 0;

        // R6 / R5 with both engines
        an_en = 1;
        do_restart();
        do_recfg();
        tick(1);
        an_done = 1; tick(1); an_done = 0;
        tick(1);
        lt_fail = 1; tick(1); lt_fail = 0;
        check("R6 renegotiate on training fail", int'(an_start), 1);
        tick(1);
        an_done = 1; tick(1); an_done = 0;
        tick(1);
        fail_resp = 1;
        lt_fail = 1; tick(1); lt_fail = 0;
        check("R5 failure goes to data", int'(link_ready), 1);

        // R11 link-fail timer
        lf_tmr_dis = 1; link_fail = 1;
        tick(LF_TMO * 3);
        check("R11 disabled timer keeps link", int'(link_ready), 1);
        lf_tmr_dis = 0;
        tick(LF_TMO - 1);
        check("R11 still up before expiry", int'(link_ready), 1);
        tick(1);
        check("R11 expiry restarts bring-up", int'(recfg_req), 1);
        check("R13 ready low after expiry", int'(link_ready), 0);
        link_fail = 0;
        do_recfg();
        check("R2 renegotiation after link loss", int'(an_start), 1);
        tick(4);

        finish_run();
    end

endmodule